// File: doc/BRIEF.md
# Refresh Interval Timer with Sticky Status Flags

This block paces memory refresh. An 8-bit up-counter advances on a prescaled tick chosen by a 3-bit select field. An 8-bit constant register holds the interval. When the counter equals the constant on a tick, the counter returns to zero and a sticky match flag is raised. A wrap of the counter from its top value raises a separate sticky overflow flag. Each flag has its own enable, and the single interrupt line is the OR of the two enabled flags.

Software reaches three registers over a small register bus and clears a flag by writing 0 to its bit. Writing 1 to a flag bit leaves the flag as it is. A power-on reset clears everything. A manual reset clears only the counter, so software settings and pending flags survive it.

Top module: `refresh_timer`

## Requirements
- R1: After power-on reset (por_n low), the status register reads 0x0000, the counter reads 0x0000 and the constant register reads 0x00FF.
- R2: In the status word at address 0, bits 15 to 8 always read 0 and writing to them has no effect. Bits 6 to 3, bit 1 and bit 0 read back exactly what was last written to them.
- R3: On a tick where the counter equals the constant, the match flag (status bit 7) is set and the counter becomes 0. On any other tick the counter increments by one, modulo 256.
- R4: A bus write to address 0 with 0 in bit 7 clears the match flag, and with 0 in bit 2 clears the overflow flag. A 1 in either bit leaves that flag unchanged.
- R5: If a flag's hardware set event and a software clear of that flag fall in the same cycle, the flag ends up 1.
- R6: Select field value 0 (status bits 5:3) stops the counter. A value k from 1 to 7 advances the counter on cycles where tick_en[k-1] is 1.
- R7: On a tick where the counter is 0xFF and does not equal the constant, the counter becomes 0x00 and the overflow flag (status bit 2) is set.
- R8: irq is 1 exactly when (bit 7 AND bit 6) OR (bit 2 AND bit 1) of the status word is 1.
- R9: While mrst is 1, the counter is cleared to 0, ticks have no effect and no flag is set. The status and constant registers keep their values.
- R10: Address 1 holds the counter and address 2 holds the constant, each in bits 7:0 with bits 15:8 reading 0. Address 3 reads 0 and ignores writes. A bus write to the counter takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| mrst | input | 1 | Manual reset, synchronous, clears only the counter |
| addr | input | 2 | Register select: 0 status, 1 counter, 2 constant, 3 unused |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for addr, combinational |
| tick_en | input | 7 | Prescaled tick enables, one per nonzero select value |
| irq | output | 1 | Interrupt request |

## Verification
A wrong counter value shows at address 1 in the cycle after the tick that produced it. It also moves the next match or wrap to the wrong tick, so the flags at address 0 and irq go wrong a few ticks later. A flag that is lost or set when it should not be shows on irq in the next cycle whenever its enable is set. The bench compares the read data and irq against a behavioural model on every clock, so any such divergence is reported within one cycle of reaching the ports.

// File: rtl/rt_pkg.sv
package rt_pkg;

    // Status word layout; bit order is what software decodes.
    typedef struct packed {
        logic       cmf;   // bit 7: match flag
        logic       cmie;  // bit 6: match interrupt enable
        logic [2:0] cks;   // bits 5:3: tick select
        logic       ovf;   // bit 2: overflow flag
        logic       ovie;  // bit 1: overflow interrupt enable
        logic       lim;   // bit 0: limit select (stored only)
    } rt_csr_t;

    localparam int unsigned CSR_W = $bits(rt_csr_t);

    localparam logic [1:0] ADDR_CSR = 2'd0;
    localparam logic [1:0] ADDR_CNT = 2'd1;
    localparam logic [1:0] ADDR_COR = 2'd2;

endpackage

// File: rtl/rt_tick_sel.sv
module rt_tick_sel #(
    parameter int unsigned SEL_W     = 3,
    parameter int unsigned NUM_TICKS = 7
) (
    input  logic [SEL_W-1:0]     sel,
    input  logic [NUM_TICKS-1:0] tick_en,
    output logic                 tick
);

    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < NUM_TICKS; i++) begin
            if (sel == SEL_W'(i + 1)) begin
                tick = tick_en[i];
            end
        end
    end

endmodule

// File: rtl/rt_counter.sv
module rt_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             mrst,
    input  logic             tick,
    input  logic             wr_cnt,
    input  logic             wr_cor,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cor,
    output logic             match_evt,
    output logic             ovf_evt
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cor;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       live_tick;
    logic       equal;

    always_comb begin
        live_tick = tick && !mrst;
        equal     = (st_q.cnt == st_q.cor);
        match_evt = live_tick && equal;
        ovf_evt   = live_tick && !equal && (st_q.cnt == CNT_TOP);

        st_d = st_q;
        if (wr_cor) begin
            st_d.cor = wdata;
        end
        if (mrst) begin
            st_d.cnt = '0;
        end else if (wr_cnt) begin
            st_d.cnt = wdata;
        end else if (live_tick) begin
            st_d.cnt = equal ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.cnt <= '0;
            st_q.cor <= CNT_TOP;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
    assign cor = st_q.cor;

    // R3
    match_clr_chk: assert property (@(posedge clk) disable iff (!por_n)
        (match_evt && !wr_cnt) |=> (st_q.cnt == '0));

    // R6
    stop_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!tick && !wr_cnt && !mrst) |=> $stable(st_q.cnt));

    // R9
    mrst_clr_chk: assert property (@(posedge clk) disable iff (!por_n)
        mrst |=> (st_q.cnt == '0));

endmodule

// File: rtl/rt_csr.sv
module rt_csr
    import rt_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             wr,
    input  logic [CSR_W-1:0] wdata,
    input  logic             match_evt,
    input  logic             ovf_evt,
    output rt_csr_t          csr,
    output logic             irq
);

    rt_csr_t csr_d, csr_q;
    rt_csr_t wv;

    always_comb begin
        wv    = rt_csr_t'(wdata);
        csr_d = csr_q;
        if (wr) begin
            csr_d.cmie = wv.cmie;
            csr_d.cks  = wv.cks;
            csr_d.ovie = wv.ovie;
            csr_d.lim  = wv.lim;
            csr_d.cmf  = csr_q.cmf & wv.cmf;
            csr_d.ovf  = csr_q.ovf & wv.ovf;
        end
        if (match_evt) csr_d.cmf = 1'b1;
        if (ovf_evt)   csr_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            csr_q <= '0;
        end else begin
            csr_q <= csr_d;
        end
    end

    assign csr = csr_q;
    assign irq = (csr_q.cmf & csr_q.cmie) | (csr_q.ovf & csr_q.ovie);

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!por_n)
        match_evt |=> csr_q.cmf);

    // R5
    ovf_set_chk: assert property (@(posedge clk) disable iff (!por_n)
        ovf_evt |=> csr_q.ovf);

    // R4
    clr_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        (wr && !wdata[7] && !match_evt) |=> !csr_q.cmf);

    // R9
    csr_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!wr && !match_evt && !ovf_evt) |=> $stable(csr_q));

endmodule

// File: rtl/refresh_timer.sv
module refresh_timer
    import rt_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned SEL_W     = 3,
    parameter int unsigned NUM_TICKS = 7
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  logic                 mrst,
    input  logic [1:0]           addr,
    input  logic                 wr_en,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [DATA_W-1:0]    rd_data,
    input  logic [NUM_TICKS-1:0] tick_en,
    output logic                 irq
);

    rt_csr_t          csr;
    logic             tick;
    logic [CNT_W-1:0] cnt, cor;
    logic             match_evt, ovf_evt;
    logic             wr_csr, wr_cnt, wr_cor;

    assign wr_csr = wr_en && (addr == ADDR_CSR);
    assign wr_cnt = wr_en && (addr == ADDR_CNT);
    assign wr_cor = wr_en && (addr == ADDR_COR);

    rt_tick_sel #(.SEL_W(SEL_W), .NUM_TICKS(NUM_TICKS)) u_sel (
        .sel     (csr.cks),
        .tick_en (tick_en),
        .tick    (tick)
    );

    rt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .por_n     (por_n),
        .mrst      (mrst),
        .tick      (tick),
        .wr_cnt    (wr_cnt),
        .wr_cor    (wr_cor),
        .wdata     (wr_data[CNT_W-1:0]),
        .cnt       (cnt),
        .cor       (cor),
        .match_evt (match_evt),
        .ovf_evt   (ovf_evt)
    );

    rt_csr u_csr (
        .clk       (clk),
        .por_n     (por_n),
        .wr        (wr_csr),
        .wdata     (wr_data[CSR_W-1:0]),
        .match_evt (match_evt),
        .ovf_evt   (ovf_evt),
        .csr       (csr),
        .irq       (irq)
    );

    always_comb begin
        unique case (addr)
            ADDR_CSR: rd_data = DATA_W'(csr);
            ADDR_CNT: rd_data = DATA_W'(cnt);
            ADDR_COR: rd_data = DATA_W'(cor);
            default:  rd_data = '0;
        endcase
    end

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        (addr == ADDR_CSR) |-> (rd_data[DATA_W-1:CSR_W] == '0));

endmodule

// File: tb/refresh_timer_test.sv
`timescale 1ns/1ps
module refresh_timer_test;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        mrst = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'h0;
    logic [15:0] rd_data;
    logic [6:0]  tick_en = 7'h0;
    logic        irq;

    int vectors = 0;
    int miscompares = 0;
    string cur_req = "R1";

    // behavioural model state
    int m_csr = 0;
    int m_cnt = 0;
    int m_cor = 255;

    always #2.5 clk = ~clk;

    refresh_timer uut (
        .clk(clk), .por_n(por_n), .mrst(mrst), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .tick_en(tick_en), .irq(irq)
    );

    function automatic int exp_read(int a);
        case (a)
            0: return m_csr;
            1: return m_cnt;
            2: return m_cor;
            default: return 0;
        endcase
    endfunction

    function automatic bit exp_irq();
        return ((m_csr >> 7) & (m_csr >> 6) & 1) != 0 ||
               ((m_csr >> 2) & (m_csr >> 1) & 1) != 0;
    endfunction

    task automatic compare();
        int er;
        bit ei;
        er = exp_read(int'(addr));
        ei = exp_irq();
        vectors++;
        if (int'(rd_data) != er || irq != ei) begin
            miscompares++;
            $display("FAIL %s addr=%0d actual rd=%h irq=%0b expected rd=%h irq=%0b",
                     cur_req, addr, rd_data, irq, er[15:0], ei);
        end
    endtask

    task automatic model_update();
        int  sel;
        bit  tk, evm, evo, wcsr, wcnt, wcor;
        sel  = (m_csr >> 3) & 7;
        tk   = (sel != 0) && tick_en[sel-1] && !mrst;
        evm  = tk && (m_cnt == m_cor);
        evo  = tk && (m_cnt != m_cor) && (m_cnt == 255);
        wcsr = wr_en && addr == 2'd0;
        wcnt = wr_en && addr == 2'd1;
        wcor = wr_en && addr == 2'd2;
        if (wcor) m_cor = int'(wr_data[7:0]);
        if (mrst)       m_cnt = 0;
        else if (wcnt)  m_cnt = int'(wr_data[7:0]);
        else if (tk)    m_cnt = evm ? 0 : (m_cnt + 1) % 256;
        if (wcsr) begin
            int keep;
            keep  = m_csr & (int'(wr_data) | 'h7B) & 'h84;
            m_csr = keep | (int'(wr_data) & 'h7B);
        end
        if (evm) m_csr = m_csr | 'h80;
        if (evo) m_csr = m_csr | 'h04;
    endtask

    // one clock: drive, compare, advance model
    task automatic step(input logic [1:0] a, input logic w, input logic [15:0] d,
                        input logic [6:0] te, input logic mr);
        @(negedge clk);
        addr = a; wr_en = w; wr_data = d; tick_en = te; mrst = mr;
        #1 compare();
        @(posedge clk);
        model_update();
    endtask

    task automatic idle(input int n, input logic [1:0] a, input logic [6:0] te);
        for (int i = 0; i < n; i++) step(a, 1'b0, 16'h0, te, 1'b0);
    endtask

    initial begin
        #1_000_000;
        miscompares++;
        $display("FAIL R1 watchdog actual=timeout expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        por_n = 1'b1;

        // R1: reset values of each register
        cur_req = "R1";
        idle(1, 2'd0, 7'h7F);
        idle(1, 2'd1, 7'h7F);
        idle(1, 2'd2, 7'h7F);

        // R2: reserved upper bits ignore writes, control bits stored
        cur_req = "R2";
        step(2'd0, 1'b1, 16'hFF43, 7'h0, 1'b0);   // cks=0, enables + lim
        idle(2, 2'd0, 7'h7F);
        step(2'd0, 1'b1, 16'h0000, 7'h0, 1'b0);
        idle(1, 2'd0, 7'h0);

        // R10: address 3 reads 0, writes ignored; counter/constant access
        cur_req = "R10";
        step(2'd3, 1'b1, 16'hFFFF, 7'h0, 1'b0);
        idle(1, 2'd3, 7'h0);
        step(2'd2, 1'b1, 16'hAB05, 7'h0, 1'b0);   // constant = 5
        idle(1, 2'd2, 7'h0);

        // R6: select 0 stops counter, select 1 runs on tick_en[0]
        cur_req = "R6";
        idle(4, 2'd1, 7'h7F);
        step(2'd0, 1'b1, 16'h0048, 7'h0, 1'b0);   // cks=1, cmie=1
        idle(3, 2'd1, 7'h7E);                      // bit0 low: no ticks
        idle(3, 2'd1, 7'h01);

        // R3 / R8: run to the match, flag and irq rise
        cur_req = "R3";
        idle(6, 2'd0, 7'h01);
        idle(3, 2'd1, 7'h01);
        cur_req = "R8";
        idle(1, 2'd0, 7'h00);

        // R4: writing 1 keeps, writing 0 clears
        cur_req = "R4";
        step(2'd0, 1'b1, 16'h00C8, 7'h0, 1'b0);
        idle(1, 2'd0, 7'h0);
        step(2'd0, 1'b1, 16'h0048, 7'h0, 1'b0);
        idle(1, 2'd0, 7'h0);

        // R5: clear and set in the same cycle
        cur_req = "R5";
        step(2'd1, 1'b1, 16'h0005, 7'h0, 1'b0);   // counter = constant
        step(2'd0, 1'b1, 16'h0048, 7'h01, 1'b0);  // tick + clear together
        idle(2, 2'd0, 7'h0);

        // R7: wrap from 0xFF sets overflow; irq via overflow enable
        cur_req = "R7";
        step(2'd2, 1'b1, 16'h0010, 7'h0, 1'b0);
        step(2'd1, 1'b1, 16'h00FE, 7'h0, 1'b0);
        step(2'd0, 1'b1, 16'h000A, 7'h0, 1'b0);   // cks=1, ovie=1, clear cmf
        idle(3, 2'd1, 7'h01);
        idle(2, 2'd0, 7'h00);

        // R10: write to counter beats a tick in the same cycle
        cur_req = "R10";
        step(2'd1, 1'b1, 16'h0033, 7'h01, 1'b0);
        idle(1, 2'd1, 7'h0);

        // R9: manual reset clears only the counter
        cur_req = "R9";
        step(2'd1, 1'b0, 16'h0, 7'h01, 1'b1);
        step(2'd0, 1'b0, 16'h0, 7'h01, 1'b1);
        step(2'd2, 1'b0, 16'h0, 7'h01, 1'b1);
        idle(1, 2'd1, 7'h0);
        idle(1, 2'd0, 7'h0);

        // R6 / R3 / R7: broad random traffic against the model
        cur_req = "R6";
        for (int i = 0; i < 4000; i++) begin
            logic [1:0]  a;
            logic        w;
            logic [15:0] d;
            a = 2'($urandom_range(0, 3));
            w = ($urandom_range(0, 15) == 0);
            d = 16'($urandom);
            if (a == 2'd2) d[7:0] = 8'($urandom_range(200, 255));
            step(a, w, d, 7'($urandom), ($urandom_range(0, 63) == 0));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule